// File: doc/BRIEF.md
# Video Control Register Bank with Two-Wire Write Slave

This block holds the configuration of a video enhancement processor. A host writes it over a two-wire serial bus, with the block acting only as a receiving slave. A transfer consists of a start condition, the 7-bit device address with a write direction bit, a register pointer byte, and then any number of data bytes. Each of these bytes is acknowledged by pulling the data line low. After each data byte the pointer advances, so one transfer can fill several of the four 8-bit registers in sequence.

The serial lines are brought into the system clock domain and edge-detected, and all state runs on that clock. Most fields drive their outputs as soon as their byte is accepted. The two picture-mode bits are an exception. They are written into a pending copy, and the active mode takes that copy only on clock edges where vertical sync and the data-request input are both high. This lets mode changes land inside vertical blanking. The 3-bit measurement-line code is decoded into a line number through a fixed non-linear table.

Top module: `vidctl_i2c_regbank`

## Requirements
- R1: After synchronous reset the outputs are: mode 0; narrow frame, split screen and VCR off; noise reduction on; 8-bit input on; frame luminance 0; lower threshold 4; upper threshold 16; measurement line 4; all force fields 0; the data line released.
- R2: The block acknowledges only the address byte 0x2A (address 0010101, then direction bit 0). After any other address byte it does not acknowledge, and it acknowledges nothing and changes no register until the next start condition.
- R3: The address 0010101 followed by direction bit 1 (byte 0x2B) is not acknowledged.
- R4: After an accepted address, the pointer byte and every data byte are acknowledged by driving the data line low during the ninth clock. The pull-down changes only while the serial clock is low.
- R5: After each data byte the pointer advances by one, so consecutive data bytes load registers 1, 2, 3 and so on in a single transfer.
- R6: Data bytes aimed at a pointer of 4 or above are acknowledged and change no output.
- R7: Register 0 fields, which take effect at once: bit 5 narrow frame, bit 3 split screen, bit 2 VCR, bit 1 noise reduction, bit 0 8-bit input. Bit 4 has no function.
- R8: Register 0 bits 7:6 (mode: 0 normal, 1 multi-picture, 2 still-in-picture, 3 picture-in-still) reach the mode output only on a clock edge where vertical sync and data request are both high. One of the two being high alone does not change it.
- R9: Register 2 bits 7:5 decode to a measurement line: 000→4, 001→0, 010→1, 011→2, 100→3, 101→5, 110→7, 111→6. Bits 4:0 are the upper threshold.
- R10: Register 1 holds frame luminance in bits 7:5 and the lower threshold in bits 4:0. Register 3 holds force-class enable in bit 7, class in 6:5, force-coefficient enable in bit 4 and coefficient in 3:0.
- R11: A start condition in the middle of a byte abandons that byte and begins a new address phase. The abandoned bits write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | High to pull the data line low (open drain) |
| vsync_i | input | 1 | Vertical sync, high during blanking |
| dreq_i | input | 1 | Data request from the memory controller |
| mode_o | output | 2 | Active picture mode |
| narrow_frame_o | output | 1 | Narrow frame enable |
| split_screen_o | output | 1 | Split-screen demo enable |
| vcr_o | output | 1 | VCR source, freezes noise adaptation |
| nr_en_o | output | 1 | Noise reduction enable |
| in8_o | output | 1 | 8-bit input word width |
| frame_luma_o | output | 3 | Frame grey level |
| sn_low_o | output | 5 | Lower noise class threshold |
| sn_high_o | output | 5 | Upper noise class threshold |
| meas_line_o | output | 3 | Decoded measurement line |
| force_class_en_o | output | 1 | Force noise class |
| force_class_o | output | 2 | Forced class |
| force_coef_en_o | output | 1 | Force filter coefficient |
| force_coef_o | output | 4 | Forced coefficient code |

## Verification
The assertions assume that the serial lines move only at rates far below the system clock, and that data changes only while the clock is low, except for start and stop conditions. They also assume that vertical sync and data request are synchronous to the system clock. The bench drives its bus master on falling system-clock edges, with twenty cycles per quarter bit. It changes data only in the low clock phase and releases the line for every acknowledge slot. It drives sync and request on falling edges, so that each commit window is a whole number of cycles.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 4;
  localparam int SUB_W    = 8;
  localparam logic [6:0] DEV_ADDR = 7'b0010101;

  typedef enum logic [2:0] {
    RX_IDLE, RX_ADDR, RX_ADDR_ACK, RX_SUB, RX_SUB_ACK, RX_DATA, RX_DATA_ACK
  } rx_state_t;

  function automatic logic [REG_W-1:0] reg_default(input int idx);
    case (idx)
      0:       reg_default = 8'h03;
      1:       reg_default = 8'h04;
      2:       reg_default = 8'h10;
      default: reg_default = 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] line_decode(input logic [2:0] code);
    case (code)
      3'b000:  line_decode = 3'd4;
      3'b001:  line_decode = 3'd0;
      3'b010:  line_decode = 3'd1;
      3'b011:  line_decode = 3'd2;
      3'b100:  line_decode = 3'd3;
      3'b101:  line_decode = 3'd5;
      3'b110:  line_decode = 3'd7;
      default: line_decode = 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b1;
          else     stage_q[g] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b1;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= stage_q[STAGES-1];
  end

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = stage_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_wr_rx.sv
module i2c_wr_rx
  import vidctl_pkg::*;
#(
  parameter logic [6:0] ADDR7 = DEV_ADDR,
  parameter int NREG  = NUM_REGS,
  parameter int PTR_W = SUB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             sda_rise,
  input  logic             sda_fall,
  output logic             sda_pull,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);
  localparam logic [7:0] ADDR_BYTE = {ADDR7, 1'b0};

  rx_state_t        state;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [PTR_W-1:0] ptr;
  logic             start_c, stop_c, byte_end;

  assign start_c  = scl_lvl & sda_fall;
  assign stop_c   = scl_lvl & sda_rise;
  assign byte_end = scl_fall && (bit_cnt == 4'd8);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        state    <= RX_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        state    <= RX_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          RX_ADDR, RX_SUB, RX_DATA: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_end) begin
              if (state == RX_ADDR) begin
                if (shreg == ADDR_BYTE) begin
                  state    <= RX_ADDR_ACK;
                  sda_pull <= 1'b1;
                end else begin
                  state <= RX_IDLE;
                end
              end else if (state == RX_SUB) begin
                ptr      <= shreg[PTR_W-1:0];
                state    <= RX_SUB_ACK;
                sda_pull <= 1'b1;
              end else begin
                wr_en    <= 1'b1;
                wr_addr  <= ptr;
                wr_data  <= shreg;
                if (ptr < PTR_W'(NREG)) ptr <= ptr + 1'b1;
                state    <= RX_DATA_ACK;
                sda_pull <= 1'b1;
              end
            end
          end
          RX_ADDR_ACK, RX_SUB_ACK, RX_DATA_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bit_cnt  <= '0;
              state    <= (state == RX_ADDR_ACK) ? RX_SUB : RX_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4: acknowledge pull-down moves only while the clock is low
  assert_pull_clk_low_R4: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> !$past(scl_lvl));

  // R2: address acknowledge only after the device's own write byte
  assert_ack_own_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (state == RX_ADDR_ACK) |-> (shreg == ADDR_BYTE));

  // R5: pointer advances after every data byte inside the bank
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (state == RX_DATA && byte_end && !start_c && !stop_c && ptr < PTR_W'(NREG))
    |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import vidctl_pkg::*;
#(
  parameter int NREG  = NUM_REGS,
  parameter int PTR_W = SUB_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [PTR_W-1:0]           wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic                       vsync_i,
  input  logic                       dreq_i,
  output logic [NREG-1:0][REG_W-1:0] cfg_o,
  output logic [1:0]                 mode_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) cfg_o[i] <= reg_default(i);
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (wr_addr == PTR_W'(i)) cfg_o[i] <= wr_data;
    end
  end

  // pending mode sits in cfg_o[0][7:6]; commit window is blanking plus request
  always_ff @(posedge clk) begin
    if (rst)                   mode_o <= reg_default(0)[7:6];
    else if (vsync_i && dreq_i) mode_o <= cfg_o[0][7:6];
  end

  // R8: active mode changes only after a commit window
  assert_mode_commit_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_o != $past(mode_o)) |-> $past(vsync_i && dreq_i));

  // R6: writes past the bank leave every register unchanged
  assert_ignore_beyond_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= PTR_W'(NREG)) |=> $stable(cfg_o));
endmodule

// File: rtl/vidctl_i2c_regbank.sv
module vidctl_i2c_regbank
  import vidctl_pkg::*;
#(
  parameter logic [6:0] ADDR7 = DEV_ADDR,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic       vsync_i,
  input  logic       dreq_i,
  output logic [1:0] mode_o,
  output logic       narrow_frame_o,
  output logic       split_screen_o,
  output logic       vcr_o,
  output logic       nr_en_o,
  output logic       in8_o,
  output logic [2:0] frame_luma_o,
  output logic [4:0] sn_low_o,
  output logic [4:0] sn_high_o,
  output logic [2:0] meas_line_o,
  output logic       force_class_en_o,
  output logic [1:0] force_class_o,
  output logic       force_coef_en_o,
  output logic [3:0] force_coef_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic                          wr_en;
  logic [SUB_W-1:0]              wr_addr;
  logic [7:0]                    wr_data;
  logic [NUM_REGS-1:0][REG_W-1:0] cfg;
  logic                          unused_r0_b4;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  i2c_wr_rx #(.ADDR7(ADDR7), .NREG(NUM_REGS), .PTR_W(SUB_W)) u_rx (
    .clk(clk), .rst(rst),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .sda_pull(sda_pull_o), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  ctl_regfile #(.NREG(NUM_REGS), .PTR_W(SUB_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vsync_i(vsync_i), .dreq_i(dreq_i), .cfg_o(cfg), .mode_o(mode_o));

  assign narrow_frame_o   = cfg[0][5];
  assign unused_r0_b4     = cfg[0][4];
  assign split_screen_o   = cfg[0][3];
  assign vcr_o            = cfg[0][2];
  assign nr_en_o          = cfg[0][1];
  assign in8_o            = cfg[0][0];
  assign frame_luma_o     = cfg[1][7:5];
  assign sn_low_o         = cfg[1][4:0];
  assign meas_line_o      = line_decode(cfg[2][7:5]);
  assign sn_high_o        = cfg[2][4:0];
  assign force_class_en_o = cfg[3][7];
  assign force_class_o    = cfg[3][6:5];
  assign force_coef_en_o  = cfg[3][4];
  assign force_coef_o     = cfg[3][3:0];
endmodule

// File: tb/sim_vidctl_i2c_regbank.sv
module sim_vidctl_i2c_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic vsync = 1'b0, dreq = 1'b0;
  logic sda_pull, sda_line;
  logic [1:0] mode; logic nf, ss, vcr, nr, in8;
  logic [2:0] luma, line; logic [4:0] sl, su;
  logic fce, fke; logic [1:0] fc; logic [3:0] fk;
  int checks = 0, errors = 0;
  bit done = 0;

  assign sda_line = m_sda & ~sda_pull;
  always #(CLK_PERIOD/2) clk = ~clk;

  vidctl_i2c_regbank u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .vsync_i(vsync), .dreq_i(dreq), .mode_o(mode), .narrow_frame_o(nf),
    .split_screen_o(ss), .vcr_o(vcr), .nr_en_o(nr), .in8_o(in8),
    .frame_luma_o(luma), .sn_low_o(sl), .sn_high_o(su), .meas_line_o(line),
    .force_class_en_o(fce), .force_class_o(fc), .force_coef_en_o(fke),
    .force_coef_o(fk));

  function automatic logic [31:0] snap();
    return {1'b0, mode, nf, ss, vcr, nr, in8, luma, sl, su, line, fce, fc, fke, fk};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1; wq(Q); m_scl = 1; wq(Q); m_sda = 0; wq(Q); m_scl = 0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 0; wq(Q); m_scl = 1; wq(Q); m_sda = 1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wq(Q); m_scl = 1; wq(Q); m_scl = 0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1; wq(Q); m_scl = 1; wq(Q/2);
    ack = !sda_line;
    wq(Q/2); m_scl = 0; wq(Q);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0); chk("R1 nf", nf, 0); chk("R1 ss", ss, 0);
    chk("R1 vcr", vcr, 0); chk("R1 nr", nr, 1); chk("R1 in8", in8, 1);
    chk("R1 luma", luma, 0); chk("R1 sl", sl, 4); chk("R1 su", su, 16);
    chk("R1 line", line, 4); chk("R1 force", {fce, fc, fke, fk}, 0);
    chk("R1 pull", sda_pull, 0);
  endtask

  task automatic t_reg0();
    bit a;
    bus_start();
    send_byte(8'h2A, a); chk("R2 own addr ack", a, 1);
    send_byte(8'h00, a); chk("R4 sub ack", a, 1);
    send_byte(8'h6C, a); chk("R4 data ack", a, 1);
    bus_stop();
    chk("R7 nf", nf, 1); chk("R7 ss", ss, 1); chk("R7 vcr", vcr, 1);
    chk("R7 nr", nr, 0); chk("R7 in8", in8, 0);
    chk("R8 mode held", mode, 0);
  endtask

  task automatic t_mode();
    bit a;
    vsync = 1; dreq = 0; wq(10); chk("R8 vsync alone", mode, 0);
    vsync = 0; dreq = 1; wq(10); chk("R8 dreq alone", mode, 0);
    vsync = 1; dreq = 1; wq(1); vsync = 0; dreq = 0; wq(2);
    chk("R8 commit", mode, 1);
    bus_start(); send_byte(8'h2A, a); send_byte(8'h00, a); send_byte(8'hEC, a); bus_stop();
    chk("R8 second held", mode, 1);
    vsync = 1; dreq = 1; wq(1); vsync = 0; dreq = 0; wq(2);
    chk("R8 second commit", mode, 3);
  endtask

  task automatic t_bad_addr();
    bit a; logic [31:0] s0 = snap();
    bus_start();
    send_byte(8'h54, a); chk("R2 foreign addr nack", a, 0);
    send_byte(8'h01, a); chk("R2 no ack after foreign", a, 0);
    send_byte(8'hFF, a); chk("R2 no ack data", a, 0);
    bus_stop();
    chk("R2 regs untouched", snap(), s0);
    bus_start();
    send_byte(8'h2B, a); chk("R3 read nack", a, 0);
    send_byte(8'h01, a); send_byte(8'hFF, a);
    bus_stop();
    chk("R3 regs untouched", snap(), s0);
  endtask

  task automatic t_autoinc();
    bit a; int acks = 0;
    bus_start(); send_byte(8'h2A, a);
    send_byte(8'h01, a); acks += a;
    send_byte(8'hA7, a); acks += a;
    send_byte(8'h79, a); acks += a;
    send_byte(8'hD5, a); acks += a;
    bus_stop();
    chk("R4 all acks", acks, 4);
    chk("R10 luma", luma, 5); chk("R10 sl", sl, 7);
    chk("R5 su", su, 25); chk("R9 line 011", line, 2);
    chk("R10 fce", fce, 1); chk("R10 fc", fc, 2);
    chk("R10 fke", fke, 1); chk("R10 fk", fk, 5);
  endtask

  task automatic t_beyond();
    bit a; logic [31:0] s0;
    bus_start(); send_byte(8'h2A, a); send_byte(8'h03, a);
    send_byte(8'h00, a);
    s0 = snap();
    send_byte(8'h55, a); chk("R6 ack beyond", a, 1);
    send_byte(8'h66, a); chk("R6 ack beyond 2", a, 1);
    bus_stop();
    chk("R6 unchanged", snap(), s0);
    bus_start(); send_byte(8'h2A, a); send_byte(8'h07, a);
    send_byte(8'hFF, a); chk("R6 ack sub 7", a, 1);
    bus_stop();
    chk("R6 unchanged sub 7", snap(), s0);
  endtask

  task automatic t_line();
    bit a; int exp;
    for (int c = 0; c < 8; c++) begin
      case (c)
        0: exp = 4; 1: exp = 0; 2: exp = 1; 3: exp = 2;
        4: exp = 3; 5: exp = 5; 6: exp = 7; default: exp = 6;
      endcase
      bus_start(); send_byte(8'h2A, a); send_byte(8'h02, a);
      send_byte({c[2:0], 5'd16}, a); bus_stop();
      chk("R9 line decode", line, exp);
      chk("R9 su", su, 16);
    end
  endtask

  task automatic t_restart();
    bit a; logic [2:0] l0 = luma; logic [4:0] s0 = sl;
    bus_start(); send_byte(8'h2A, a); send_byte(8'h01, a);
    send_bits(8'hFF, 4);
    bus_start();
    send_byte(8'h2A, a); chk("R11 addr after restart", a, 1);
    send_byte(8'h03, a); send_byte(8'h12, a); bus_stop();
    chk("R11 luma kept", luma, l0); chk("R11 sl kept", sl, s0);
    chk("R11 fce", fce, 0); chk("R11 fke", fke, 1); chk("R11 fk", fk, 2);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wq(5); rst = 0; wq(5);
    t_reset();
    t_reg0();
    t_mode();
    t_bad_addr();
    t_autoinc();
    t_beyond();
    t_line();
    t_restart();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule